// File: doc/BRIEF.md
# Serial-Controlled SAR Conversion Sequencer

This block is the digital sequencer of a four-input successive-approximation converter that runs entirely on an external serial clock. It watches the serial data line for a start bit and collects an eight-bit command. The command sets the input multiplexer, the sampling mode, the result length and the power policy. Sampling starts partway through the command. After the last command bit the sequencer holds the sample and resolves one result bit per clock. It does this through a trial code sent to the capacitive DAC and a comparator answer that comes back.

Results leave on the serial output MSB first, after a one-clock busy pulse. The next command may arrive while the current result is still shifting out, so conversions can run back to back every 15 clocks (12-bit) or every 11 clocks (8-bit). Both serial outputs are released whenever the chip select is high. A shutdown pin stops everything at once.

Top module: `sar_seq`

## Requirements
- R1: While chip select is low and no command is being received, low bits on `din` are ignored; the first high bit sampled on a rising `sclk` edge is the start bit (command bit 7) and begins a frame.
- R2: Command bits follow the start bit MSB first: bits 6..4 form the channel field, bit 3 the short-result request, bit 2 the single-ended flag (1 = single-ended), bits 1..0 the power code. `mux_sel` shows the channel field from the 4th rising edge of the frame, and `mux_se` shows bit 2 from the 6th.
- R3: `smp_en` (acquire) is high for exactly three clocks, from the 5th to the 8th rising edge of the frame, and low otherwise; its fall is the hold instant.
- R4: `busy` goes high on the falling edge after the 8th rising edge of the frame and stays high for exactly one clock.
- R5: From the falling edge after the 9th rising edge, `dout` gives one result bit per falling edge, MSB first, in straight binary. Each bit is the comparator answer for a trial code in which that bit is set on top of the bits already kept. `dout` is low after the LSB and outside result bits.
- R6: With `mode_pin` low every result is 12 bits. With it high, command bit 3 = 0 gives 12 bits and bit 3 = 1 gives 8 bits (the top 8 bits of the 12-bit result).
- R7: A new start bit is accepted no earlier than the 16th rising edge of a 12-bit frame or the 12th of an 8-bit frame. High bits on `din` before that are ignored, and the new command may overlap the previous result output.
- R8: `dout_oe` and `busy_oe` equal the inverse of `cs_n`. A rising `cs_n` mid-frame abandons the frame, and the next frame after `cs_n` falls again is handled normally.
- R9: `pwr_on` is high while a frame is being received or converted. Between frames it stays high only if the last launched power code is not 00. Codes 01, 10 and 11 all keep power on. After reset it is low.
- R10: A low `shdn_n` forces `pwr_on` low at once, aborts any frame (`busy` and `dout` stay low), and keeps the last power code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial and conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial command input, sampled on rising `sclk` |
| mode_pin | input | 1 | Allows the short-result request when high |
| shdn_n | input | 1 | Active-low shutdown |
| cmp_hi | input | 1 | Comparator answer: held input is at least the DAC code |
| dout | output | 1 | Serial result, updated on falling `sclk` |
| dout_oe | output | 1 | Output enable for `dout` |
| busy | output | 1 | Conversion-start pulse, updated on falling `sclk` |
| busy_oe | output | 1 | Output enable for `busy` |
| mux_sel | output | 3 | Channel field for the analog multiplexer |
| mux_se | output | 1 | Single-ended (1) or differential (0) input |
| smp_en | output | 1 | Acquire when high, hold when low |
| dac_code | output | 12 | Trial code for the capacitive DAC |
| pwr_on | output | 1 | Analog section powered |

## Verification
The hardest case to reach is the overlapped stream. In it, the next command's start bit lands on the first permitted edge while the previous result is still leaving. High bits also fall on every edge of the window where a start must be refused. The bench builds streams of up to six frames with zero to three spare clocks, 8-bit and 12-bit lengths and random filler bits in the forbidden window. It models the held analog value so that the expected serial bits of every frame are fixed before the stream runs. Directed runs cover full-scale and zero inputs, long idle preambles, the mode pin overriding the short request, and a chip-select or shutdown that lands in the middle of a conversion.

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             din,
  input  logic             mode_pin,
  input  logic             shdn_n,
  input  logic             cmp_hi,
  output logic             dout,
  output logic             dout_oe,
  output logic             busy,
  output logic             busy_oe,
  output logic [2:0]       mux_sel,
  output logic             mux_se,
  output logic             smp_en,
  output logic [RES_W-1:0] dac_code,
  output logic             pwr_on
);
  localparam int CW = $clog2(RES_W + 1);
  localparam int PW = $clog2(RES_W + 4);
  localparam logic [CW-1:0] LEN_L = CW'(RES_W);
  localparam logic [CW-1:0] LEN_S = CW'(SHORT_W);
  localparam logic [PW-1:0] GAP_L = PW'(RES_W + 3);
  localparam logic [PW-1:0] GAP_S = PW'(SHORT_W + 3);
  localparam logic [RES_W-1:0] TOP = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] ONE = {{(RES_W-1){1'b0}}, 1'b1};

  logic [2:0]       rx_cnt;
  logic [2:0]       ctl;
  logic [CW-1:0]    cv_left;
  logic [PW-1:0]    pos;
  logic [RES_W-1:0] sar, trial;
  logic             short_q, keep_q, busy_r, obit, dout_q, busy_q;

  wire abort    = cs_n || !shdn_n;
  wire start_ok = (pos == '0) || (pos >= (short_q ? GAP_S : GAP_L));
  wire launch   = (rx_cnt == 3'd7);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= '0; ctl <= '0; cv_left <= '0; pos <= '0;
      sar <= '0; trial <= '0; short_q <= 1'b0; keep_q <= 1'b0;
      busy_r <= 1'b0; obit <= 1'b0; mux_sel <= '0; mux_se <= 1'b0;
    end else if (abort) begin
      rx_cnt <= '0; cv_left <= '0; pos <= '0;
      sar <= '0; trial <= '0; busy_r <= 1'b0; obit <= 1'b0;
    end else begin
      busy_r <= 1'b0;
      obit   <= 1'b0;
      if (pos != '0 && pos < GAP_L) pos <= pos + PW'(1);
      if (rx_cnt == '0) begin
        if (din && start_ok) begin
          rx_cnt <= 3'd1;
          pos    <= PW'(1);
        end
      end else begin
        ctl    <= {ctl[1:0], din};
        rx_cnt <= launch ? 3'd0 : rx_cnt + 3'd1;
        if (rx_cnt == 3'd3) mux_sel <= {ctl[1:0], din};
        if (rx_cnt == 3'd5) mux_se  <= din;
        if (launch) begin
          short_q <= mode_pin & ctl[2];
          keep_q  <= ctl[0] | din;
          busy_r  <= 1'b1;
          sar     <= TOP;
          trial   <= TOP;
          cv_left <= (mode_pin & ctl[2]) ? LEN_S : LEN_L;
        end
      end
      if (cv_left != '0) begin
        obit    <= cmp_hi;
        sar     <= (cmp_hi ? sar : (sar & ~trial)) | (trial >> 1);
        trial   <= trial >> 1;
        cv_left <= cv_left - CW'(1);
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0; busy_q <= 1'b0;
    end else if (abort) begin
      dout_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      dout_q <= obit; busy_q <= busy_r;
    end
  end

  assign dout     = dout_q;
  assign busy     = busy_q;
  assign dout_oe  = !cs_n;
  assign busy_oe  = !cs_n;
  assign smp_en   = (rx_cnt >= 3'd5);
  assign dac_code = sar;
  assign pwr_on   = shdn_n & (keep_q | (rx_cnt != '0) | (cv_left != '0));

  // R4
  busy_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    busy_r |=> !busy_r);

  // R5
  sar_trial_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (cv_left != '0) |-> ($countones(trial) == 1 && (sar & (trial - ONE)) == '0 && (sar & trial) != '0));

  // R8
  cs_abort_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> (rx_cnt == '0 && cv_left == '0 && !busy_r));

  // R10
  shdn_abort_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !shdn_n |=> (rx_cnt == '0 && cv_left == '0 && !obit));

  // R3
  hold_launch_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    ($fell(smp_en) && !$past(abort)) |-> busy_r);
endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
  localparam int MAXE = 256;

  logic sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic mode_pin = 1'b0, shdn_n = 1'b1;
  logic cmp_hi;
  logic dout, dout_oe, busy, busy_oe, mux_se, smp_en, pwr_on;
  logic [2:0]  mux_sel;
  logic [11:0] dac_code;

  sar_seq u_dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .mode_pin(mode_pin),
    .shdn_n(shdn_n), .cmp_hi(cmp_hi), .dout(dout), .dout_oe(dout_oe),
    .busy(busy), .busy_oe(busy_oe), .mux_sel(mux_sel), .mux_se(mux_se),
    .smp_en(smp_en), .dac_code(dac_code), .pwr_on(pwr_on)
  );

  always #2.5 sclk = ~sclk;

  logic [11:0] vin [8];
  logic [11:0] held = 12'h000;
  always @(negedge smp_en) held = vin[mux_sel];
  assign cmp_hi = (held >= dac_code);

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] fr_ctl [8];
  int fr_gap [8];
  bit keep_m = 1'b0;
  int unsigned seed_sink;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int res_len(input logic [7:0] c, input logic mp);
    return (mp && c[3]) ? 8 : 12;
  endfunction

  task automatic tick(input logic b);
    din = b;
    @(posedge sclk);
    @(negedge sclk);
    #1;
  endtask

  task automatic run_stream(input int nf, input int lead, input bit noise, input string req);
    bit ds [MAXE]; bit ed [MAXE]; bit eb [MAXE]; bit es [MAXE]; bit ea [MAXE];
    bit kl [MAXE]; bit kv [MAXE]; bit mv [MAXE];
    logic [3:0] mx [MAXE];
    logic [7:0] c;
    logic [11:0] r;
    int n, p, tot;
    bit kc;
    kc = keep_m;
    p = lead + 1;
    for (int f = 0; f < nf; f++) begin
      c = fr_ctl[f] | 8'h80;
      n = res_len(c, mode_pin);
      r = vin[c[6:4]];
      for (int b = 0; b < 8; b++) ds[p+b] = c[7-b];
      if (noise) for (int e = p + 8; e < p + n + 3; e++) ds[e] = 1'($urandom_range(0, 1));
      for (int e = p + 4; e <= p + 6; e++) es[e] = 1'b1;
      eb[p+7] = 1'b1;
      for (int j = 0; j < n; j++) ed[p+8+j] = r[11-j];
      for (int e = p; e <= p + 6 + n; e++) ea[e] = 1'b1;
      kl[p+7] = 1'b1;
      kv[p+7] = (c[1:0] != 2'b00);
      mv[p+7] = 1'b1;
      mx[p+7] = {c[6:4], c[2]};
      p += n + 3 + fr_gap[f];
    end
    tot = p + 20;
    @(negedge sclk); #1;
    cs_n = 1'b0;
    for (int e = 1; e <= tot; e++) begin
      tick(ds[e]);
      if (kl[e]) kc = kv[e];
      check({req, " R5 dout"}, int'(dout), int'(ed[e]));
      check({req, " R4 busy"}, int'(busy), int'(eb[e]));
      check({req, " R3 acquire"}, int'(smp_en), int'(es[e]));
      check({req, " R9 power"}, int'(pwr_on), int'(ea[e] | kc));
      if (mv[e]) begin
        check("R2 channel field", int'(mux_sel), int'(mx[e][3:1]));
        check("R2 single-ended flag", int'(mux_se), int'(mx[e][0]));
      end
      if (e == 1) check("R8 enables low cs", int'({dout_oe, busy_oe}), 3);
    end
    din = 1'b0;
    cs_n = 1'b1;
    keep_m = kc;
  endtask

  initial begin
    #750000;
    total++;
    bad++;
    $display("FAIL watchdog all requirements: actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    logic [7:0] ca;
    int nf;
    seed_sink = $urandom(32'h1F2E);
    for (int i = 0; i < 8; i++) vin[i] = 12'h000;
    for (int i = 0; i < 8; i++) fr_gap[i] = 0;
    repeat (4) @(posedge sclk);
    @(negedge sclk); #1;
    check("R8 reset dout_oe", int'(dout_oe), 0);
    check("R8 reset busy_oe", int'(busy_oe), 0);
    check("R9 reset power", int'(pwr_on), 0);
    rst_n = 1'b1;

    // R5 full scale, powered code
    vin[1] = 12'hFFF; fr_ctl[0] = 8'b1_001_0_1_11; fr_gap[0] = 2;
    run_stream(1, 0, 1'b0, "R5");
    // R9 zero input, power-down code
    vin[6] = 12'h000; fr_ctl[0] = 8'b1_110_0_0_00; fr_gap[0] = 0;
    run_stream(1, 3, 1'b0, "R9");
    // R1 long idle preamble, reserved code
    vin[3] = 12'hA5C; fr_ctl[0] = 8'b1_011_0_1_01;
    run_stream(1, 20, 1'b0, "R1");
    // R6 short results back to back with filler highs
    mode_pin = 1'b1; vin[2] = 12'h801; vin[5] = 12'h7FE;
    fr_ctl[0] = 8'b1_010_1_1_10; fr_ctl[1] = 8'b1_101_1_0_11; fr_ctl[2] = 8'b1_010_1_1_00;
    run_stream(3, 1, 1'b1, "R6");
    // R7 pin low overrides short request, minimum spacing with filler highs
    mode_pin = 1'b0;
    fr_ctl[0] = 8'b1_101_1_1_11; fr_ctl[1] = 8'b1_010_1_0_00;
    run_stream(2, 0, 1'b1, "R7");

    for (int k = 0; k < 25; k++) begin
      for (int i = 0; i < 8; i++) vin[i] = 12'($urandom);
      mode_pin = 1'($urandom_range(0, 1));
      nf = $urandom_range(1, 6);
      for (int f = 0; f < nf; f++) begin
        fr_ctl[f] = 8'($urandom);
        fr_gap[f] = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
      end
      run_stream(nf, $urandom_range(0, 3), 1'($urandom_range(0, 1)), "R5");
    end

    // R8 chip select rises during conversion
    mode_pin = 1'b0; vin[4] = 12'h3C3; ca = 8'b1_100_0_1_11;
    @(negedge sclk); #1;
    cs_n = 1'b0;
    for (int e = 1; e <= 12; e++) tick((e <= 8) ? ca[8-e] : 1'b0);
    cs_n = 1'b1;
    #1;
    check("R8 dout released", int'(dout_oe), 0);
    check("R8 busy released", int'(busy_oe), 0);
    @(posedge sclk); @(negedge sclk); #1;
    check("R8 idle after abort keeps code", int'(pwr_on), 1);
    keep_m = 1'b1;
    for (int i = 0; i < 8; i++) fr_gap[i] = 0;
    fr_ctl[0] = ca;
    run_stream(1, 0, 1'b0, "R8");

    // R10 shutdown during conversion
    vin[0] = 12'hFFF; ca = 8'b1_000_0_1_00;
    @(negedge sclk); #1;
    cs_n = 1'b0;
    for (int e = 1; e <= 10; e++) tick((e <= 8) ? ca[8-e] : 1'b0);
    shdn_n = 1'b0;
    #1;
    check("R10 power drops at once", int'(pwr_on), 0);
    for (int e = 11; e <= 26; e++) begin
      tick(1'b0);
      check("R10 dout quiet", int'(dout), 0);
      check("R10 busy quiet", int'(busy), 0);
      check("R10 power held low", int'(pwr_on), 0);
    end
    shdn_n = 1'b1;
    #1;
    check("R10 released idle power code 00", int'(pwr_on), 0);
    cs_n = 1'b1;
    keep_m = 1'b0;
    vin[7] = 12'h5A5; fr_ctl[0] = 8'b1_111_0_0_10;
    run_stream(1, 2, 1'b0, "R10");

    finish_up();
  end
endmodule